// File: doc/BRIEF.md
# Multimode Timer/Counter

This block is a general-purpose counter driven by a count clock. A gate input and an up/down input control it. A three-bit mode code picks one of six behaviours.

The first three modes count or measure and never produce a pulse:
- In the free counting mode the gate enables counting.
- In the period measurement mode the gate marks a window that runs from one rising edge to the next.
- In the width measurement mode the window runs from a rising gate edge to the falling edge that follows it.

The other three modes generate a pulse after a programmed delay, and the pulse lasts for a programmed width:
- In the gated one-shot mode the gate acts as an enable that pauses progress.
- In the triggered one-shot mode a rising gate edge starts the sequence.
- In the pulse-train mode a rising gate edge starts a sequence that then repeats.

The mode code, the starting count, the delay and the width are taken into the block only in a cycle where the synchronous reset or the arm input is active. New values can therefore be prepared while an operation runs, and they take effect at the next arm. The gate and up/down inputs are assumed to be synchronous to the count clock already. The counter value and a done flag can be read at the outputs at any time.

Top module: `gptimer_core`

## Requirements
- R1: In mode code 0, every clock edge with `gate_i` high adds 1 to `count_o` when `updown_i` is 1, or subtracts 1 when it is 0. An edge with `gate_i` low leaves `count_o` unchanged. Counting starts from the captured initial value.
- R2: Counting wraps modulo 2^CNT_W in both directions.
- R3: In mode code 1, the first rising gate edge after arming starts the measurement and the next rising edge ends it. After the end, `count_o` holds the initial value plus or minus P, where P is the number of clock edges between the two rising edges, and `done_o` is 1.
- R4: In mode code 2, `count_o` ends at the initial value plus or minus H, where H is the number of edges that sample the gate high after its first rise. `done_o` rises with the falling gate edge.
- R5: In mode code 3, progress happens only on edges that sample the gate high. Counting those edges as k = 1, 2, …, `pulse_o` is 1 exactly while D < k ≤ D+W. `done_o` is 1 once k > D+W.
- R6: In mode code 4, let edge t be the first edge that samples the gate high after it was low. `pulse_o` is 1 after edges t+D through t+D+W−1 and 0 otherwise. Later gate edges are ignored, and `done_o` is 1 from edge t+D+W onward.
- R7: In mode code 5, after the trigger edge t, `pulse_o` is 1 after edge t+i exactly when (i mod (D+W)) ≥ D. This continues until the next arm, and `done_o` stays 0.
- R8: A delay or width value below 2 acts as 2.
- R9: The mode, initial count, delay and width inputs are captured only at reset or arm. Changing them at any other time has no effect on the outputs.
- R10: Mode codes 6 and 7 are idle: `count_o` keeps the initial value, and `pulse_o` and `done_o` stay 0.
- R11: After reset, `count_o` equals the initial value presented during reset, and `pulse_o` and `done_o` are 0.
- R12: `pulse_o` stays 0 in modes 0 to 2. Once `done_o` is raised, it holds together with `count_o` until the next arm or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Synchronous active-low reset; also captures configuration |
| arm_i | input | 1 | Synchronous re-arm: captures configuration and restarts |
| gate_i | input | 1 | Gate: enable, measurement window or trigger, depending on mode |
| updown_i | input | 1 | 1 counts up, 0 counts down |
| mode_i | input | 3 | Operating mode code (0 to 5 used) |
| init_i | input | CNT_W | Initial count value |
| delay_i | input | CNT_W | Pulse delay in clock cycles |
| width_i | input | CNT_W | Pulse width in clock cycles |
| count_o | output | CNT_W | Counter value (phase counter in pulse modes) |
| pulse_o | output | 1 | Generated pulse |
| done_o | output | 1 | Measurement or one-shot finished |

## Verification
The bench builds the block with CNT_W = 8. With that width, wrap-around in both directions is reached within a few gated cycles, and the tests can start counting just below the top of the range or just above zero. The delay and width values used stay small: 2 to 4 cycles, plus the sub-minimum values 0 and 1. This keeps whole pulse trains, and the clamp to 2, visible within a few dozen cycles. Gate patterns with pauses and extra edges exercise the gated pause and the rule that later triggers are ignored.

// File: rtl/gptimer_pkg.sv
`timescale 1ns/1ps
// Package: shared mode codes and engine state encodings for the timer.
package gptimer_pkg;

    // Operating mode codes; numeric values are part of the external contract.
    typedef enum logic [2:0] {
        MODE_COUNT  = 3'd0,
        MODE_PERIOD = 3'd1,
        MODE_WIDTH  = 3'd2,
        MODE_GATED  = 3'd3,
        MODE_TRIG   = 3'd4,
        MODE_TRAIN  = 3'd5,
        MODE_RSV6   = 3'd6,
        MODE_RSV7   = 3'd7
    } gpt_mode_e;

    // Measurement engine progress.
    typedef enum logic [1:0] {
        MS_WAIT = 2'd0,
        MS_RUN  = 2'd1,
        MS_DONE = 2'd2
    } meas_st_e;

    // Pulse engine phase.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DELAY  = 2'd1,
        PH_HIGH   = 2'd2,
        PH_FINISH = 2'd3
    } pulse_ph_e;

endpackage

// File: rtl/gptimer_edge.sv
`timescale 1ns/1ps
// Module: gptimer_edge
// Detects rising and falling edges of the gate against its previous sample.
// Assumes the gate is already synchronous to clk.
module gptimer_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    output logic rise_o,
    output logic fall_o
);
    logic gate_q;

    // Purpose: remember the gate level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_i;
    end

    // Purpose: compare current and previous gate levels.
    always_comb begin
        rise_o = gate_i & ~gate_q;
        fall_o = ~gate_i & gate_q;
    end
endmodule

// File: rtl/gptimer_meas.sv
`timescale 1ns/1ps
// Module: gptimer_meas
// Counting and measurement engine for the free-count, period and width modes.
// Assumes restart coincides with the capture of mode and initial value;
// the count register is loaded straight from the initial value input then.
module gptimer_meas
    import gptimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  gpt_mode_e        mode,
    input  logic             gate,
    input  logic             rise,
    input  logic             fall,
    input  logic             up,
    input  logic [CNT_W-1:0] init_ld,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] step;
    meas_st_e         st_q;

    // Purpose: next value one count away in the selected direction.
    always_comb begin
        step = up ? (cnt_q + ONE) : (cnt_q - ONE);
    end

    // Purpose: advance the counter and measurement state per mode.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= init_ld;
            st_q  <= MS_WAIT;
        end else begin
            case (mode)
                MODE_COUNT: begin
                    if (gate) cnt_q <= step;
                end
                MODE_PERIOD: begin
                    case (st_q)
                        MS_WAIT: if (rise) begin
                            cnt_q <= step;
                            st_q  <= MS_RUN;
                        end
                        MS_RUN: begin
                            if (rise) st_q  <= MS_DONE;
                            else      cnt_q <= step;
                        end
                        default: ;
                    endcase
                end
                MODE_WIDTH: begin
                    case (st_q)
                        MS_WAIT: if (rise) begin
                            cnt_q <= step;
                            st_q  <= MS_RUN;
                        end
                        MS_RUN: begin
                            if (fall) st_q  <= MS_DONE;
                            else      cnt_q <= step;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign done_o = (st_q == MS_DONE);
endmodule

// File: rtl/gptimer_pulse.sv
`timescale 1ns/1ps
// Module: gptimer_pulse
// Delay-then-width pulse engine for the gated one-shot, triggered one-shot
// and pulse-train modes. Assumes delay and width were captured at arm;
// values below 2 are raised to 2.
module gptimer_pulse
    import gptimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  gpt_mode_e        mode,
    input  logic             gate,
    input  logic             rise,
    input  logic [CNT_W-1:0] delay_q,
    input  logic [CNT_W-1:0] width_q,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pulse_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);

    pulse_ph_e        ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] dly_eff;
    logic [CNT_W-1:0] wid_eff;
    logic             start;
    logic             adv;
    logic             active;

    // Purpose: clamp timing values and decode start/advance per mode.
    always_comb begin
        dly_eff = (delay_q < TWO) ? TWO : delay_q;
        wid_eff = (width_q < TWO) ? TWO : width_q;
        active  = (mode == MODE_GATED) || (mode == MODE_TRIG) || (mode == MODE_TRAIN);
        start   = (mode == MODE_GATED) ? gate : rise;
        adv     = (mode == MODE_GATED) ? gate : 1'b1;
    end

    // Purpose: step through idle, delay, high and finish phases.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else if (active) begin
            case (ph_q)
                PH_IDLE: if (start) begin
                    ph_q  <= PH_DELAY;
                    cnt_q <= ONE;
                end
                PH_DELAY: if (adv) begin
                    if (cnt_q >= dly_eff) begin
                        ph_q  <= PH_HIGH;
                        cnt_q <= ONE;
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
                PH_HIGH: if (adv) begin
                    if (cnt_q >= wid_eff) begin
                        if (mode == MODE_TRAIN) begin
                            ph_q  <= PH_DELAY;
                            cnt_q <= ONE;
                        end else begin
                            ph_q  <= PH_FINISH;
                        end
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cnt_o   = cnt_q;
    assign pulse_o = (ph_q == PH_HIGH);
    assign done_o  = (ph_q == PH_FINISH);
endmodule

// File: rtl/gptimer_core.sv
`timescale 1ns/1ps
// Module: gptimer_core (top)
// Multimode timer/counter: captures configuration at reset or arm, then runs
// either the measurement engine or the pulse engine selected by the mode.
// Assumes gate_i and updown_i are synchronous to clk.
module gptimer_core
    import gptimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             gate_i,
    input  logic             updown_i,
    input  logic [2:0]       mode_i,
    input  logic [CNT_W-1:0] init_i,
    input  logic [CNT_W-1:0] delay_i,
    input  logic [CNT_W-1:0] width_i,
    output logic [CNT_W-1:0] count_o,
    output logic             pulse_o,
    output logic             done_o
);
    gpt_mode_e        mode_q;
    logic [CNT_W-1:0] delay_q;
    logic [CNT_W-1:0] width_q;
    logic             rise;
    logic             fall;
    logic [CNT_W-1:0] m_cnt;
    logic [CNT_W-1:0] p_cnt;
    logic             m_done;
    logic             p_done;
    logic             pulse_mode;

    // Purpose: capture configuration only at reset or arm.
    always_ff @(posedge clk) begin
        if (!rst_n || arm_i) begin
            mode_q  <= gpt_mode_e'(mode_i);
            delay_q <= delay_i;
            width_q <= width_i;
        end
    end

    gptimer_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_i (gate_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    gptimer_meas #(.CNT_W(CNT_W)) u_meas (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (arm_i),
        .mode    (mode_q),
        .gate    (gate_i),
        .rise    (rise),
        .fall    (fall),
        .up      (updown_i),
        .init_ld (init_i),
        .cnt_o   (m_cnt),
        .done_o  (m_done)
    );

    gptimer_pulse #(.CNT_W(CNT_W)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (arm_i),
        .mode    (mode_q),
        .gate    (gate_i),
        .rise    (rise),
        .delay_q (delay_q),
        .width_q (width_q),
        .cnt_o   (p_cnt),
        .pulse_o (pulse_o),
        .done_o  (p_done)
    );

    // Purpose: select which engine's counter is visible.
    always_comb begin
        pulse_mode = (mode_q == MODE_GATED) || (mode_q == MODE_TRIG) || (mode_q == MODE_TRAIN);
        count_o    = pulse_mode ? p_cnt : m_cnt;
        done_o     = m_done | p_done;
    end
endmodule

// File: rtl/gptimer_chk.sv
`timescale 1ns/1ps
// Module: gptimer_chk
// Property checker for gptimer_core, attached through bind below.
module gptimer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm_i,
    input logic             gate_i,
    input logic             updown_i,
    input logic [2:0]       mode_q,
    input logic [CNT_W-1:0] count_o,
    input logic             pulse_o,
    input logic             done_o
);
    // R1: gated count step upward
    a_r1_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd0 && gate_i && updown_i && !arm_i)
        |=> count_o == $past(count_o) + CNT_W'(1));

    // R1: gate low holds the count
    a_r1_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd0 && !gate_i && !arm_i) |=> $stable(count_o));

    // R12: done holds until arm
    a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !arm_i) |=> done_o);

    // R12: measured value frozen once done
    a_r12_result_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !arm_i && (mode_q == 3'd1 || mode_q == 3'd2)) |=> $stable(count_o));

    // R12: no pulse in measurement modes
    a_r12_no_pulse_meas: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd0 || mode_q == 3'd1 || mode_q == 3'd2) |-> !pulse_o);

    // R8: a pulse lasts at least two cycles unless cut by arm
    a_r8_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_o) && !$past(arm_i)) |-> $past(pulse_o, 2));

    // R10: reserved codes stay idle
    a_r10_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd6 || mode_q == 3'd7) |-> (!pulse_o && !done_o));
endmodule

bind gptimer_core gptimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm_i),
    .gate_i   (gate_i),
    .updown_i (updown_i),
    .mode_q   (mode_q),
    .count_o  (count_o),
    .pulse_o  (pulse_o),
    .done_o   (done_o)
);

// File: tb/gptimer_core_bench.sv
`timescale 1ns/1ps
// Directed bench for gptimer_core; one task per scenario.
module gptimer_core_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         arm_i = 1'b0;
    logic         gate_i = 1'b0;
    logic         updown_i = 1'b1;
    logic [2:0]   mode_i = 3'd0;
    logic [W-1:0] init_i = '0;
    logic [W-1:0] delay_i = 8'd2;
    logic [W-1:0] width_i = 8'd2;
    logic [W-1:0] count_o;
    logic         pulse_o;
    logic         done_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    gptimer_core #(.CNT_W(W)) u_gptimer_core (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .gate_i(gate_i),
        .updown_i(updown_i), .mode_i(mode_i), .init_i(init_i),
        .delay_i(delay_i), .width_i(width_i), .count_o(count_o),
        .pulse_o(pulse_o), .done_o(done_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input int md, input int ini, input int dly, input int wid);
        @(negedge clk);
        mode_i = md[2:0]; init_i = ini[W-1:0];
        delay_i = dly[W-1:0]; width_i = wid[W-1:0];
        gate_i = 1'b0; arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; init_i = 8'd5; mode_i = 3'd0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R11", "count", int'(count_o), 5);
        check("R11", "pulse", int'(pulse_o), 0);
        check("R11", "done", int'(done_o), 0);
    endtask

    task automatic t_count();
        arm(0, 10, 2, 2);
        mode_i = 3'd4; init_i = 8'd99;          // R9: ignored until next arm
        updown_i = 1'b1; gate_i = 1'b1; tick(5);
        check("R1", "up count", int'(count_o), 15);
        updown_i = 1'b0; tick(3);
        check("R1", "down count", int'(count_o), 12);
        gate_i = 1'b0; tick(4);
        check("R1", "gate low hold", int'(count_o), 12);
        check("R9", "mode kept", int'(pulse_o), 0);
        check("R12", "no pulse", int'(pulse_o), 0);
    endtask

    task automatic t_wrap();
        arm(0, 254, 2, 2);
        updown_i = 1'b1; gate_i = 1'b1; tick(4);
        check("R2", "wrap up", int'(count_o), 2);
        arm(0, 1, 2, 2);
        updown_i = 1'b0; gate_i = 1'b1; tick(3);
        check("R2", "wrap down", int'(count_o), 254);
        gate_i = 1'b0;
    endtask

    task automatic t_period(input int ini, input logic up, input int h, input int l, input int exp);
        arm(1, ini, 2, 2);
        updown_i = up;
        tick(2);
        gate_i = 1'b1; tick(h);
        gate_i = 1'b0; tick(l);
        gate_i = 1'b1; tick(1);
        check("R3", "period count", int'(count_o), exp);
        check("R3", "done", int'(done_o), 1);
        gate_i = 1'b0; tick(2); gate_i = 1'b1; tick(3);
        check("R12", "period held", int'(count_o), exp);
        check("R12", "done held", int'(done_o), 1);
        gate_i = 1'b0;
    endtask

    task automatic t_width();
        arm(2, 0, 2, 2);
        updown_i = 1'b1;
        gate_i = 1'b1; tick(6);
        check("R4", "not done yet", int'(done_o), 0);
        gate_i = 1'b0; tick(1);
        check("R4", "width count", int'(count_o), 6);
        check("R4", "done", int'(done_o), 1);
        gate_i = 1'b1; tick(3); gate_i = 1'b0; tick(1);
        check("R12", "width held", int'(count_o), 6);
    endtask

    task automatic t_gated();
        logic [15:0] pat = 16'b0110_1110_0110_1010;
        int k = 0;
        int d = 2;
        int w = 2;
        arm(3, 0, d, w);
        for (int i = 0; i < 16; i++) begin
            gate_i = pat[i];
            tick(1);
            if (pat[i]) k++;
            check("R5", "gated pulse", int'(pulse_o), (k > d && k <= d + w) ? 1 : 0);
            check("R5", "gated done", int'(done_o), (k > d + w) ? 1 : 0);
        end
        gate_i = 1'b0;
    endtask

    task automatic t_trig(input string req, input int dly, input int wid, input int de, input int we);
        arm(4, 0, dly, wid);
        mode_i = 3'd0; delay_i = 8'd9; width_i = 8'd9; init_i = 8'd77;   // R9
        tick(1);
        gate_i = 1'b1;
        for (int i = 0; i < de + we + 5; i++) begin
            tick(1);
            check(req, "trig pulse", int'(pulse_o), (i >= de && i < de + we) ? 1 : 0);
            check(req, "trig done", int'(done_o), (i >= de + we) ? 1 : 0);
            gate_i = ~gate_i;   // R6: later edges ignored
        end
        gate_i = 1'b0;
    endtask

    task automatic t_train();
        arm(5, 0, 2, 3);
        tick(1);
        gate_i = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick(1);
            check("R7", "train pulse", int'(pulse_o), ((i % 5) >= 2) ? 1 : 0);
            check("R7", "train done", int'(done_o), 0);
            gate_i = ~gate_i;
        end
        gate_i = 1'b0;
    endtask

    task automatic t_reserved();
        arm(7, 42, 2, 2);
        for (int i = 0; i < 6; i++) begin
            gate_i = ~gate_i;
            tick(1);
        end
        check("R10", "count", int'(count_o), 42);
        check("R10", "pulse", int'(pulse_o), 0);
        check("R10", "done", int'(done_o), 0);
        gate_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_count();
        t_wrap();
        t_period(100, 1'b1, 3, 4, 107);
        t_period(100, 1'b0, 2, 3, 95);
        t_width();
        t_gated();
        t_trig("R6", 3, 4, 3, 4);
        t_trig("R8", 0, 1, 2, 2);
        t_train();
        t_reserved();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule